// File: doc/BRIEF.md
# Input Event Word Queue

This block queues user-input events for a driver that reads them over a 32-bit register bus. A producer hands over one event per handshake as three 32-bit words: type, code and value. The block keeps them in a circular word buffer, and software takes them out one word per read of offset 0x00, so one event costs three reads. One level interrupt tells the driver that words are waiting.

The same offset 0x00 has a second use on writes, where it selects a probe page. Offset 0x04 then reports the length of the selected page, and offset 0x08 is the page data port. The interrupt stays silent until the driver finishes its probing. The driver shows this by reading the length register while the absolute-axis page (0x20003) is selected. Events that arrive before that point are held, not dropped. A build-time option gives a variant in which the interrupt dips low for one cycle after each read that leaves words behind.

Top module: `input_event_queue`

## Requirements
- R1: A bus read of offset 0x00 returns the oldest queued word. Each event is returned as type, then code, then value, and three such reads remove one event.
- R2: A read of offset 0x00 while the queue is empty returns 0. It leaves the queue and the interrupt unchanged.
- R3: `ev_ready` is high exactly when at least three word slots are free. A triplet is stored only on a cycle with `ev_valid` and `ev_ready` both high, so no part of a refused triplet is ever kept.
- R4: Before the driver is ready, `irq` stays low even when words are queued.
- R5: The driver becomes ready on the first read of offset 0x04 while the selected page is 0x20003. That page must be the value of the latest write to offset 0x00. A length read with any other page selected does not arm the block. Once armed, it stays armed until reset.
- R6: Events pushed before arming are kept and come out in order after arming.
- R7: Once the block is armed, `irq` is high whenever the queue holds words. It goes low on the clock edge that commits the read of the last word. After reset, `irq` is low.
- R8: A read of offset 0x04 returns NAME_LEN for page 0x00000, BITS_LEN for any page 0x1xxxx (0x10000 plus an event type), ABS_LEN for page 0x20003, and 0 for any other page. A read of offset 0x08 returns 0.
- R9: With PULSE_MODE=1, `irq` is low for exactly one cycle after a read that leaves words queued, and then returns high.
- R10: A write to offset 0x00 only changes the selected page. It never adds, removes or reorders queued words.
- R11: The word order holds across the wrap of the circular buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; takes effect at the clock edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| ev_valid | input | 1 | Producer offers one event triplet |
| ev_ready | output | 1 | At least three word slots are free |
| ev_type | input | 32 | Event type word |
| ev_code | input | 32 | Event code word |
| ev_value | input | 32 | Event value word |
| irq | output | 1 | Pending-words interrupt |

## Verification
The bench walks the arming handshake through its near misses. It selects 0x20003 but overwrites it before the length read, and it reads length with a neighbouring page selected. A design that arms too early, or that latches the magic page instead of the latest one, would raise `irq` during probing. The queue is filled to capacity over a wrap, and a producer keeps pushing while `ev_ready` is low. A design that stored a partial triplet, or that misjudged free space after one read, would show a stray word or a wrong `ev_ready`. Reads of an empty queue are followed by fresh pushes, so a pointer that moved on an empty read would give out-of-order words. The pulse variant runs beside the level one, so a missing or doubled gap cycle shows up at once.

// File: rtl/evq_pkg.sv
package evq_pkg;
  localparam int WORD_W = 32;

  // byte offsets on the register bus
  localparam int OFS_QUEUE = 0;  // read: next word, write: page select
  localparam int OFS_LEN   = 4;
  localparam int OFS_DATA  = 8;

  // probe page selectors
  localparam logic [WORD_W-1:0] PAGE_NAME    = 32'h0000_0000;
  localparam logic [15:0]       PAGE_BITS_HI = 16'h0001;
  localparam logic [WORD_W-1:0] PAGE_ABS     = 32'h0002_0003;

  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/evq_store.sv
module evq_store import evq_pkg::*; #(
  parameter  int DEPTH  = 12,
  localparam int SLOTS  = DEPTH / 3,
  localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_en,
  input  word_t [2:0]      push_words,
  input  logic             pop_req,
  output word_t            head_word,
  output logic [CNT_W-1:0] count_q,
  output logic [CNT_W-1:0] count_nxt,
  output logic             room,
  output logic             popped
);
  logic              push_ok;
  logic [SLOT_W-1:0] wr_slot_q, wr_slot_nxt;
  logic [SLOT_W-1:0] rd_slot_q, rd_slot_nxt;
  logic [1:0]        rd_lane_q, rd_lane_nxt;
  word_t [2:0]       lane_rd;

  assign room    = (int'(count_q) <= DEPTH - 3);
  assign push_ok = push_en && room;
  assign popped  = pop_req && (count_q != '0);

  // one storage array per word lane; a triplet lands in one slot
  for (genvar l = 0; l < 3; l++) begin : g_lane
    word_t lane_mem [SLOTS];
    always_ff @(posedge clk) begin
      if (push_ok) lane_mem[wr_slot_q] <= push_words[l];
    end
    assign lane_rd[l] = lane_mem[rd_slot_q];
  end

  always_comb begin
    case (rd_lane_q)
      2'd0:    head_word = lane_rd[0];
      2'd1:    head_word = lane_rd[1];
      default: head_word = lane_rd[2];
    endcase
  end

  always_comb begin
    wr_slot_nxt = wr_slot_q;
    rd_slot_nxt = rd_slot_q;
    rd_lane_nxt = rd_lane_q;
    if (push_ok) begin
      wr_slot_nxt = (int'(wr_slot_q) == SLOTS - 1) ? '0 : wr_slot_q + 1'b1;
    end
    if (popped) begin
      if (rd_lane_q == 2'd2) begin
        rd_lane_nxt = 2'd0;
        rd_slot_nxt = (int'(rd_slot_q) == SLOTS - 1) ? '0 : rd_slot_q + 1'b1;
      end else begin
        rd_lane_nxt = rd_lane_q + 2'd1;
      end
    end
    count_nxt = count_q + (push_ok ? CNT_W'(3) : CNT_W'(0)) - CNT_W'(popped);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_slot_q <= '0;
      rd_slot_q <= '0;
      rd_lane_q <= '0;
      count_q   <= '0;
    end else begin
      wr_slot_q <= wr_slot_nxt;
      rd_slot_q <= rd_slot_nxt;
      rd_lane_q <= rd_lane_nxt;
      count_q   <= count_nxt;
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count_q) <= DEPTH);

  assert_triplet_whole_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_en && !room && !popped) |=> $stable(count_q));

  assert_empty_read_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && count_q == '0 && !push_en) |=> ($stable(count_q) && $stable(rd_lane_q)));
endmodule

// File: rtl/evq_regs.sv
module evq_regs import evq_pkg::*; #(
  parameter int ADDR_W   = 4,
  parameter int NAME_LEN = 8,
  parameter int BITS_LEN = 16,
  parameter int ABS_LEN  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  word_t             bus_wdata,
  input  word_t             head_word,
  input  logic              q_empty,
  output word_t             bus_rdata,
  output logic              pop_req,
  output logic              armed_q,
  output logic              armed_nxt
);
  word_t page_q, page_nxt;
  word_t len_val;
  logic  sel_queue, sel_len, sel_data;

  assign sel_queue = (bus_addr == ADDR_W'(OFS_QUEUE));
  assign sel_len   = (bus_addr == ADDR_W'(OFS_LEN));
  assign sel_data  = (bus_addr == ADDR_W'(OFS_DATA));
  assign pop_req   = bus_rd && sel_queue;

  always_comb begin
    if (page_q == PAGE_NAME)                 len_val = word_t'(NAME_LEN);
    else if (page_q[31:16] == PAGE_BITS_HI)  len_val = word_t'(BITS_LEN);
    else if (page_q == PAGE_ABS)             len_val = word_t'(ABS_LEN);
    else                                     len_val = '0;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (sel_queue)     bus_rdata = q_empty ? '0 : head_word;
      else if (sel_len)  bus_rdata = len_val;
      else if (sel_data) bus_rdata = '0;
    end
  end

  always_comb begin
    page_nxt  = page_q;
    armed_nxt = armed_q;
    if (bus_wr && sel_queue) page_nxt = bus_wdata;
    if (bus_rd && sel_len && page_q == PAGE_ABS) armed_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      page_q  <= page_nxt;
      armed_q <= armed_nxt;
    end
  end

  assert_arm_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> armed_q);

  assert_arm_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !(bus_rd && sel_len)) |=> !armed_q);
endmodule

// File: rtl/evq_irq.sv
module evq_irq #(
  parameter int PULSE_MODE = 0,
  parameter int CNT_W      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed_nxt,
  input  logic             popped,
  input  logic [CNT_W-1:0] count_nxt,
  output logic             irq
);
  logic irq_q, irq_nxt, words_left;

  assign words_left = (count_nxt != '0);

  if (PULSE_MODE != 0) begin : g_pulse
    always_comb irq_nxt = armed_nxt && words_left && !popped;

    assert_pulse_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (popped && words_left) |=> !irq);
  end else begin : g_level
    always_comb irq_nxt = armed_nxt && words_left;

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_nxt && words_left) |=> irq);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_nxt;
  end

  assign irq = irq_q;

  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (popped && !words_left) |=> !irq);
endmodule

// File: rtl/input_event_queue.sv
module input_event_queue import evq_pkg::*; #(
  parameter int DEPTH_WORDS = 12,
  parameter int ADDR_W      = 4,
  parameter int PULSE_MODE  = 0,
  parameter int NAME_LEN    = 8,
  parameter int BITS_LEN    = 16,
  parameter int ABS_LEN     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [31:0]       ev_type,
  input  logic [31:0]       ev_code,
  input  logic [31:0]       ev_value,
  output logic              irq
);
  localparam int CNT_W = $clog2(DEPTH_WORDS + 1);

  if (DEPTH_WORDS < 3 || DEPTH_WORDS % 3 != 0) begin : g_bad_depth
    $error("DEPTH_WORDS must be a positive multiple of three");
  end

  // asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  word_t [2:0]      push_words;
  word_t            head_word;
  logic [CNT_W-1:0] count_q, count_nxt;
  logic             pop_req, popped, armed_q, armed_nxt;

  assign push_words[0] = ev_type;
  assign push_words[1] = ev_code;
  assign push_words[2] = ev_value;

  evq_store #(.DEPTH(DEPTH_WORDS)) u_store (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .push_en    (ev_valid),
    .push_words (push_words),
    .pop_req    (pop_req),
    .head_word  (head_word),
    .count_q    (count_q),
    .count_nxt  (count_nxt),
    .room       (ev_ready),
    .popped     (popped)
  );

  evq_regs #(
    .ADDR_W   (ADDR_W),
    .NAME_LEN (NAME_LEN),
    .BITS_LEN (BITS_LEN),
    .ABS_LEN  (ABS_LEN)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .head_word (head_word),
    .q_empty   (count_q == '0),
    .bus_rdata (bus_rdata),
    .pop_req   (pop_req),
    .armed_q   (armed_q),
    .armed_nxt (armed_nxt)
  );

  evq_irq #(.PULSE_MODE(PULSE_MODE), .CNT_W(CNT_W)) u_irq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .armed_nxt (armed_nxt),
    .popped    (popped),
    .count_nxt (count_nxt),
    .irq       (irq)
  );

  assert_irq_gated_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    !armed_q |-> !irq);

  assert_write_keeps_queue_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (bus_wr && !bus_rd && !ev_valid) |=> $stable(count_q));
endmodule

// File: tb/input_event_queue_bench.sv
module input_event_queue_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd, ev_valid;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata, ev_type, ev_code, ev_value;
  logic [31:0] rdata, rdata_p;
  logic        ev_ready, ev_ready_p, irq, irq_p;

  int n_chk  = 0;
  int n_fail = 0;
  int held   = 0;
  bit done   = 1'b0;
  logic [31:0] exp_q[$];
  logic [31:0] got_q[$];

  always #10 clk = ~clk;  // 50 MHz

  input_event_queue #(.PULSE_MODE(0)) u_input_event_queue (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_type(ev_type),
    .ev_code(ev_code), .ev_value(ev_value), .irq(irq));

  input_event_queue #(.PULSE_MODE(1)) u_input_event_queue_pulse (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_p),
    .ev_valid(ev_valid), .ev_ready(ev_ready_p), .ev_type(ev_type),
    .ev_code(ev_code), .ev_value(ev_value), .irq(irq_p));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compares every word the bus returned
  always @(negedge clk) begin
    while (got_q.size() > 0) begin
      logic [31:0] a;
      a = got_q.pop_front();
      if (exp_q.size() == 0) chk("R1 unexpected word", a, 32'hxxxx_xxxx);
      else                   chk("R1 word order", a, exp_q.pop_front());
    end
  end

  task automatic push_event(logic [31:0] t, logic [31:0] c, logic [31:0] v);
    @(negedge clk);
    ev_valid = 1'b1; ev_type = t; ev_code = c; ev_value = v;
    while (!ev_ready) @(negedge clk);
    @(negedge clk);
    ev_valid = 1'b0;
    exp_q.push_back(t); exp_q.push_back(c); exp_q.push_back(v);
    held += 3;
  endtask

  task automatic bus_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // pop one word through the scoreboard and follow both interrupt flavours
  task automatic drain_word();
    logic [31:0] d;
    bus_read(4'h0, d);
    got_q.push_back(d);
    held--;
    chk("R7 level irq after read", {31'b0, irq}, {31'b0, held != 0});
    chk("R9 pulse gap", {31'b0, irq_p}, 32'd0);
    @(negedge clk);
    chk("R9 pulse return", {31'b0, irq_p}, {31'b0, held != 0});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ev_valid = 0; ev_type = 0; ev_code = 0; ev_value = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R7 reset irq", {31'b0, irq}, 32'd0);
    chk("R3 reset ready", {31'b0, ev_ready}, 32'd1);
    bus_read(4'h0, d);
    chk("R2 empty read value", d, 32'd0);
    chk("R2 empty read irq", {31'b0, irq}, 32'd0);

    // events before the driver is ready (R6)
    push_event(32'h1, 32'h14a, 32'h1);
    push_event(32'h3, 32'h0, 32'h1f4);
    repeat (2) @(negedge clk);
    chk("R4 irq held off", {31'b0, irq}, 32'd0);
    chk("R4 pulse irq held off", {31'b0, irq_p}, 32'd0);

    bus_write(4'h0, 32'h0);
    bus_read(4'h4, d);  chk("R8 name length", d, 32'd8);
    bus_write(4'h0, 32'h10001);
    bus_read(4'h4, d);  chk("R8 bitmap length", d, 32'd16);
    chk("R5 no arm on bitmap page", {31'b0, irq}, 32'd0);
    bus_write(4'h0, 32'h20003);
    bus_write(4'h0, 32'h5);
    bus_read(4'h4, d);  chk("R8 unknown page length", d, 32'd0);
    chk("R5 overwritten page no arm", {31'b0, irq}, 32'd0);
    bus_write(4'h0, 32'h20002);
    bus_read(4'h4, d);  chk("R8 near page length", d, 32'd0);
    chk("R5 near page no arm", {31'b0, irq}, 32'd0);
    bus_read(4'h8, d);  chk("R8 data port", d, 32'd0);
    chk("R10 writes keep room", {31'b0, ev_ready}, 32'd1);

    bus_write(4'h0, 32'h20003);
    chk("R5 select alone no arm", {31'b0, irq}, 32'd0);
    bus_read(4'h4, d);  chk("R8 abs length", d, 32'd12);
    chk("R5 armed level irq", {31'b0, irq}, 32'd1);
    chk("R5 armed pulse irq", {31'b0, irq_p}, 32'd1);

    // R1 R6 R10: buffered words come out intact after page writes
    for (int i = 0; i < 6; i++) drain_word();
    chk("R7 empty irq low", {31'b0, irq}, 32'd0);

    bus_read(4'h0, d);
    chk("R2 empty read after drain", d, 32'd0);
    chk("R2 empty read irq stays", {31'b0, irq}, 32'd0);
    push_event(32'h2, 32'h0, 32'hffff_fffd);
    chk("R5 arm persists", {31'b0, irq}, 32'd1);
    for (int i = 0; i < 3; i++) drain_word();

    // fill across the buffer wrap (R11) and test back-pressure (R3)
    for (int i = 0; i < 4; i++) push_event(32'h1, 32'h100 + i, i);
    chk("R3 full not ready", {31'b0, ev_ready}, 32'd0);
    @(negedge clk);
    ev_valid = 1'b1; ev_type = 32'hdead; ev_code = 32'hbeef; ev_value = 32'hbad;
    repeat (3) @(negedge clk);
    ev_valid = 1'b0;
    chk("R3 refused push keeps full", {31'b0, ev_ready}, 32'd0);
    drain_word();
    chk("R3 one free not ready", {31'b0, ev_ready}, 32'd0);
    drain_word();
    drain_word();
    chk("R3 three free ready", {31'b0, ev_ready}, 32'd1);
    for (int i = 0; i < 9; i++) drain_word();
    push_event(32'h4, 32'h4, 32'h7);
    push_event(32'h0, 32'h0, 32'h0);
    for (int i = 0; i < 6; i++) drain_word();
    repeat (3) @(negedge clk);
    chk("R11 scoreboard empty", exp_q.size(), 32'd0);
    chk("R7 final irq", {31'b0, irq}, 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule